// File: doc/BRIEF.md
# Rotational Sector Position Counter

This block follows the angular position of a spinning disk by counting the pulses the drive emits as each sector boundary passes the heads. The drive gives one pulse per revolution that marks the start of the track, and one pulse at every sector boundary. Both signals arrive asynchronously. The block synchronizes each one into the system clock and reacts only to its rising edge. It then keeps a sector number in the range 00 to 23. The number is available in binary and also as two decimal digits for a numeric display.

The pulses are far too brief to light an indicator in a way a person can see. For this reason each pulse drives a lamp output that stays on for a configurable hold time, which is about 50 ms by default at 100 MHz. The block also checks the track geometry. At every start-of-track pulse after the first one, it expects the count to have reached the final sector. If the count is anything else, it raises a sticky error flag. A position-valid output tells the user whether the count has been aligned to the track start since reset.

All outputs are plain status levels that are updated every cycle. There is no handshake and no back-pressure: a reader samples the outputs whenever it needs them, and no position update is ever held back waiting for a consumer.

Top module: `sector_tracker`

## Requirements
- R1: After reset, the sector number is 0, both decimal digits are 0, the position-valid output is 0, the error flag is 0 and both lamp outputs are 0.
- R2: Each rising edge of the sector input, when it does not coincide with a start-of-track edge, advances the sector number by one. From 23 (SECTORS-1) it wraps to 0, whether or not a start-of-track pulse has been seen.
- R3: A rising edge of the start-of-track input forces the sector number to 0. A sector edge that falls in the same synchronized cycle does not advance the count.
- R4: Each input passes through a two-flop synchronizer and acts only on its rising edge. A level held high for many cycles counts once. The count output changes on the third clock edge after the input rises.
- R5: The position-valid output stays 0 until the first start-of-track edge after reset. It is 1 from that point until the next reset.
- R6: At every start-of-track edge after the first, the error flag is set if the sector number just before the edge is not 23. The flag stays set until reset, and the first start-of-track edge never sets it.
- R7: `dec_tens` and `dec_ones` hold the sector number as two BCD digits, each a 4-bit binary value from 0 to 9, with tens*10+ones equal to the sector number.
- R8: Each lamp output rises together with the count update for its edge. It stays high for exactly HOLD_CYCLES cycles after the most recent edge of its input, and a new edge restarts the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| index_in | input | 1 | Asynchronous once-per-revolution pulse |
| sector_in | input | 1 | Asynchronous sector-boundary pulse |
| sector_num | output | 5 | Current sector number, binary |
| dec_tens | output | 4 | Tens digit of the sector number, BCD |
| dec_ones | output | 4 | Ones digit of the sector number, BCD |
| pos_valid | output | 1 | Count aligned to track start since reset |
| count_err | output | 1 | Sticky pulses-per-revolution mismatch |
| index_lamp | output | 1 | Stretched start-of-track indicator |
| sector_lamp | output | 1 | Stretched sector indicator |

## Verification
A start-of-track edge and a sector edge can reach the counter in the same cycle. In that case the reset to zero must win, and the mismatch check must compare against the count from before that cycle. The bench drives both inputs high on the same clock edge, right after a full revolution of 23 sector edges. It then expects a count of 0, an unchanged error flag, and both lamps lit. A second coincident case is arranged after a short revolution, where the flag must be set. A retriggered lamp is judged by counting the cycles it stays high across two close edges.

// File: rtl/sectrk_pkg.sv
package sectrk_pkg;
  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } dec2_t;

  function automatic dec2_t to_dec2(input int unsigned v);
    dec2_t r;
    r.tens = 4'((v / 10) % 10);
    r.ones = 4'(v % 10);
    return r;
  endfunction
endpackage

// File: rtl/sectrk_sync.sv
module sectrk_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [DEPTH:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[DEPTH-1:0], din};
  end

  assign rise = sh[DEPTH-1] & ~sh[DEPTH];

  // R4: an edge strobe lasts exactly one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sectrk_stretch.sv
module sectrk_stretch #(
  parameter int HOLD = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic lamp
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)          left <= '0;
    else if (trig)       left <= HW'(HOLD);
    else if (left != '0) left <= left - HW'(1);
  end

  assign lamp = (left != '0);

  // R8: a trigger lights the lamp on the next cycle
  a_r8_lamp_on: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> lamp);
  // R8: the lamp never goes dark right after a trigger
  a_r8_no_early_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lamp) |-> !$past(trig));
endmodule

// File: rtl/sectrk_count.sv
module sectrk_count #(
  parameter int SECTORS = 24,
  parameter int SW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_rise,
  input  logic          sec_rise,
  output logic [SW-1:0] cnt,
  output logic          aligned,
  output logic          err
);
  localparam logic [SW-1:0] LAST = SW'(SECTORS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      aligned <= 1'b0;
      err     <= 1'b0;
    end else if (idx_rise) begin
      if (aligned && cnt != LAST) err <= 1'b1;
      aligned <= 1'b1;
      cnt     <= '0;
    end else if (sec_rise) begin
      cnt <= (cnt == LAST) ? '0 : cnt + SW'(1);
    end
  end

  // R2: count stays inside the sector range
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R2: a lone sector edge steps the count by one with wrap
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_rise && !idx_rise) |=>
      cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + SW'(1)));
  // R3: start-of-track edge zeroes the count, even with a sector edge
  a_r3_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rise |=> cnt == '0);
  // R3: without an edge the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_rise && !sec_rise) |=> $stable(cnt));
  // R5: valid never drops outside reset
  a_r5_valid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    aligned |=> aligned);
  // R6: error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R6: error only rises on a start-of-track edge
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(idx_rise) && $past(aligned));
endmodule

// File: rtl/sector_tracker.sv
module sector_tracker #(
  parameter int SECTORS     = 24,
  parameter int HOLD_CYCLES = 5_000_000,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       index_in,
  input  logic       sector_in,
  output logic [4:0] sector_num,
  output logic [3:0] dec_tens,
  output logic [3:0] dec_ones,
  output logic       pos_valid,
  output logic       count_err,
  output logic       index_lamp,
  output logic       sector_lamp
);
  import sectrk_pkg::*;

  localparam int SW = 5;

  logic          idx_rise, sec_rise;
  logic [SW-1:0] cnt;
  dec2_t         dec;

  sectrk_sync #(.DEPTH(SYNC_DEPTH)) u_sync_idx (
    .clk(clk), .rst_n(rst_n), .din(index_in), .rise(idx_rise));
  sectrk_sync #(.DEPTH(SYNC_DEPTH)) u_sync_sec (
    .clk(clk), .rst_n(rst_n), .din(sector_in), .rise(sec_rise));

  sectrk_count #(.SECTORS(SECTORS), .SW(SW)) u_count (
    .clk(clk), .rst_n(rst_n), .idx_rise(idx_rise), .sec_rise(sec_rise),
    .cnt(cnt), .aligned(pos_valid), .err(count_err));

  sectrk_stretch #(.HOLD(HOLD_CYCLES)) u_lamp_idx (
    .clk(clk), .rst_n(rst_n), .trig(idx_rise), .lamp(index_lamp));
  sectrk_stretch #(.HOLD(HOLD_CYCLES)) u_lamp_sec (
    .clk(clk), .rst_n(rst_n), .trig(sec_rise), .lamp(sector_lamp));

  always_comb dec = to_dec2(int'(cnt));

  assign sector_num = cnt;
  assign dec_tens   = dec.tens;
  assign dec_ones   = dec.ones;

  // R7: the decimal digits agree with the binary count
  a_r7_dec_match: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(dec_tens) * 10 + int'(dec_ones)) == int'(sector_num) && dec_ones <= 4'd9);
  // R1: outputs idle right after reset
  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (sector_num == '0 && !pos_valid && !count_err));
endmodule

// File: tb/sector_tracker_tb.sv
module sector_tracker_tb;
  localparam int HOLD = 6;
  logic clk = 1'b0, rst_n = 1'b0, index_in = 1'b0, sector_in = 1'b0;
  logic [4:0] sector_num;
  logic [3:0] dec_tens, dec_ones;
  logic pos_valid, count_err, index_lamp, sector_lamp;
  int total = 0, bad = 0;
  int exp_cnt = 0;
  bit exp_valid = 0, exp_err = 0;

  always #5 clk = ~clk;

  sector_tracker #(.SECTORS(24), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .index_in(index_in), .sector_in(sector_in),
    .sector_num(sector_num), .dec_tens(dec_tens), .dec_ones(dec_ones),
    .pos_valid(pos_valid), .count_err(count_err),
    .index_lamp(index_lamp), .sector_lamp(sector_lamp));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " count"}, int'(sector_num), exp_cnt);
    chk("R7 tens", int'(dec_tens), exp_cnt / 10);
    chk("R7 ones", int'(dec_ones), exp_cnt % 10);
    chk("R5 valid", int'(pos_valid), int'(exp_valid));
    chk("R6 err", int'(count_err), int'(exp_err));
  endtask

  // drive a pulse on either/both inputs, update the model, wait for the result
  task automatic pulse(input bit idx, input bit sec, input int hold_cyc);
    @(negedge clk);
    index_in = idx; sector_in = sec;
    repeat (hold_cyc) @(negedge clk);
    index_in = 0; sector_in = 0;
    repeat (4) @(negedge clk);
    if (idx) begin
      if (exp_valid && exp_cnt != 23) exp_err = 1;
      exp_valid = 1; exp_cnt = 0;
    end else if (sec) exp_cnt = (exp_cnt + 1) % 24;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_cnt = 0; exp_valid = 0; exp_err = 0;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    check_state("R1");
    chk("R1 index lamp", int'(index_lamp), 0);
    chk("R1 sector lamp", int'(sector_lamp), 0);

    // R2: free-running wrap over all values before any index
    for (int i = 0; i < 25; i++) begin
      pulse(0, 1, 2);
      check_state("R2 free");
    end

    // R4: long level counts once; latency three edges
    @(negedge clk);
    sector_in = 1;
    @(negedge clk); chk("R4 latency e1", int'(sector_num), exp_cnt);
    @(negedge clk); chk("R4 latency e2", int'(sector_num), exp_cnt);
    @(negedge clk); chk("R4 latency e3", int'(sector_num), (exp_cnt + 1) % 24);
    repeat (10) @(negedge clk);
    sector_in = 0;
    repeat (4) @(negedge clk);
    exp_cnt = (exp_cnt + 1) % 24;
    check_state("R4 held level");

    // R5/R6: first index aligns and never flags
    pulse(1, 0, 2);
    check_state("R5 first index");

    // R2/R7: full revolution sweep
    for (int i = 0; i < 23; i++) begin
      pulse(0, 1, 1);
      check_state("R2 sweep");
    end
    // R3: coincident index and sector after full revolution
    pulse(1, 1, 2);
    check_state("R3 coincident");
    chk("R3 index lamp", int'(index_lamp), 1);
    chk("R3 sector lamp", int'(sector_lamp), 1);

    // R6: short revolution sets the flag
    for (int i = 0; i < 5; i++) pulse(0, 1, 1);
    pulse(1, 0, 2);
    check_state("R6 short rev");
    // R6: flag sticky through a good revolution
    for (int i = 0; i < 23; i++) pulse(0, 1, 1);
    pulse(1, 0, 2);
    check_state("R6 sticky");
    // R3/R6: coincident after short revolution flags too
    do_reset();
    pulse(1, 0, 2);
    for (int i = 0; i < 3; i++) pulse(0, 1, 1);
    pulse(1, 1, 2);
    check_state("R3 coincident short");
    do_reset();
    check_state("R1 reset clears");

    // R8: single pulse lamp width and onset
    begin
      int on = 0, first = -1;
      @(negedge clk);
      sector_in = 1;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (k == 2) sector_in = 0;
        if (sector_lamp) begin
          on++;
          if (first < 0) first = k;
        end
      end
      chk("R8 lamp width", on, HOLD);
      chk("R8 lamp onset", first, 3);
    end
    // R8: retrigger extends the lamp
    begin
      int on = 0, drops = 0;
      bit prev = 0;
      @(negedge clk);
      index_in = 1;
      for (int k = 1; k <= 25; k++) begin
        @(negedge clk);
        if (k == 2) index_in = 0;
        if (k == 4) index_in = 1;
        if (k == 6) index_in = 0;
        if (index_lamp) on++;
        if (prev && !index_lamp) drops++;
        prev = index_lamp;
      end
      chk("R8 retrigger width", on, 4 + HOLD);
      chk("R8 retrigger continuous", drops, 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule